// File: doc/BRIEF.md
# Program Flow Next-Address Unit

This unit works out where an 8-bit microcontroller core goes next after a flow-control instruction. Program memory is addressed in 16-bit words. Each cycle with `op_valid` high, the decoder presents these inputs:

- a five-bit operation code;
- the current program counter;
- a raw offset field and an absolute target;
- the 16-bit Z pointer;
- the status byte;
- a bit index, two compare operands and a test byte taken from a register or an I/O location;
- a flag that says whether the following instruction occupies two words.

One clock edge later the unit presents the result. This is the new program counter, the new stack pointer, the number of execution cycles the instruction costs, and a push request carrying the return address. A strobe also asks the core to set the global interrupt enable.

A return needs the saved address from data memory. For a return, the unit raises a combinational pop request with the stack address in the same cycle as the operation, and the memory answers on `pop_data` before the edge. Offsets are two's complement: 7 bits for conditional branches and 12 bits for relative jumps and calls. All program-counter arithmetic wraps at the program memory size of 2^PC_W words.

Top module: `flow_next_pc`

## Requirements
- R1: While `rst_n` is low, `res_valid`, `res_pc`, `res_sp`, `res_cycles`, `res_push`, `res_push_addr`, `res_push_data` and `res_set_i` are all zero.
- R2: Every result appears one clock after the operation is presented. `res_valid` is high exactly in the cycle after `op_valid` was high. In a cycle where `res_valid` is low, `res_push` and `res_set_i` are low, and `res_pc`, `res_sp` and `res_cycles` keep their previous values.
- R3: A relative jump (op 1) gives `pc + sext(offset[11:0]) + 1`, wrapping modulo 2^PC_W, and costs 2 cycles.
- R4: An indirect jump (op 2) gives the Z pointer and costs 2 cycles. An absolute jump (op 3) gives `target` and costs 3 cycles.
- R5: A relative call (op 4) goes to `pc + sext(offset[11:0]) + 1` and an indirect call (op 5) goes to Z. Both cost 3 cycles and raise `res_push` with `res_push_addr` = old `sp` and `res_push_data` = `pc + 1`. Both return `res_sp` = `sp - 2`.
- R6: A return (op 6) or interrupt return (op 7) drives `pop_req` high with `pop_addr` = `sp + 1` in the same cycle. The next result gives `res_pc` = `pop_data`, `res_sp` = `sp + 2` and 4 cycles. Only op 7 raises `res_set_i`.
- R7: Each skip operation skips when its condition holds:
  - op 8 when `cmp_a == cmp_b`;
  - op 9 and op 11 when `test_byte[bit_sel]` is 0;
  - op 10 and op 12 when `test_byte[bit_sel]` is 1.

  A skip advances the PC by 2 and costs 2 cycles, or by 3 and costs 3 cycles when `skip_two_word` is high. A skip whose condition fails advances by 1 and costs 1 cycle.
- R8: A branch on a set flag (op 13) or on a clear flag (op 14) tests `sreg[bit_sel]`. Flag order is C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. A taken branch gives `pc + sext(offset[6:0]) + 1` and costs 2 cycles; `offset[11:7]` is ignored. A branch not taken gives `pc + 1` and costs 1 cycle.
- R9: The signed branch op 15 is taken when N equals V, and the signed branch op 16 is taken when N differs from V. Taken and not-taken results follow R8.
- R10: A sequential operation (op 0) or any unused code (17 to 31) gives `pc + 1`, costs 1 cycle, leaves `sp` unchanged and requests nothing. `res_push` is raised only by calls, and `pop_req` only by returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code (see requirements) |
| pc | input | PC_W | Address of the current instruction |
| offset | input | 12 | Two's-complement offset; bits 6:0 used by branches |
| target | input | PC_W | Absolute jump target |
| zptr | input | 16 | Z pointer for indirect jump and call |
| sreg | input | 8 | Status flags |
| bit_sel | input | 3 | Bit index for bit skips and flag branches |
| cmp_a | input | 8 | First compare operand |
| cmp_b | input | 8 | Second compare operand |
| test_byte | input | 8 | Register or I/O byte for bit skips |
| skip_two_word | input | 1 | The instruction after this one is two words long |
| sp | input | SP_W | Current stack pointer |
| pop_req | output | 1 | Read of the saved return address |
| pop_addr | output | SP_W | Stack address of the read |
| pop_data | input | PC_W | Return address returned by memory |
| res_valid | output | 1 | Result is valid |
| res_pc | output | PC_W | Next program counter |
| res_sp | output | SP_W | Next stack pointer |
| res_cycles | output | 3 | Execution cycles of the operation |
| res_push | output | 1 | Write of a return address |
| res_push_addr | output | SP_W | Stack address of the write |
| res_push_data | output | PC_W | Return address to save |
| res_set_i | output | 1 | Set the global interrupt enable |

## Verification
Every cycle, the checker confirms the one-cycle relation between `op_valid` and `res_valid`. It also confirms that calls always lower the stack pointer by two and save `pc + 1`. It checks that returns raise the pop request at `sp + 1`, that only calls push and only an interrupt return sets the interrupt enable, and that the cycle count stays within 1 to 4.

The actual destination addresses can only be shown by the bench's scenarios. These cover:
- sign extension of both offset widths, including the ignored upper offset bits on branches;
- wrap-around at the top of program memory;
- each skip condition with one-word and two-word skipped instructions;
- the polarity of every branch kind, including the N-against-V signed branches.

// File: rtl/flow_pkg.sv
package flow_pkg;

   typedef enum logic [4:0] {
      OP_SEQ   = 5'd0,
      OP_RJMP  = 5'd1,
      OP_IJMP  = 5'd2,
      OP_JMP   = 5'd3,
      OP_RCALL = 5'd4,
      OP_ICALL = 5'd5,
      OP_RET   = 5'd6,
      OP_RETI  = 5'd7,
      OP_CPSE  = 5'd8,
      OP_SKRC  = 5'd9,
      OP_SKRS  = 5'd10,
      OP_SKIOC = 5'd11,
      OP_SKIOS = 5'd12,
      OP_BRSET = 5'd13,
      OP_BRCLR = 5'd14,
      OP_BRGE  = 5'd15,
      OP_BRLT  = 5'd16
   } flow_op_e;

   // status flag positions used by the signed branches
   localparam int FLAG_N = 2;
   localparam int FLAG_V = 3;

   localparam int OFS_LONG_W  = 12;
   localparam int OFS_SHORT_W = 7;
   localparam int CYC_W       = 3;

endpackage

// File: rtl/flow_cond.sv
module flow_cond
   import flow_pkg::*;
(
   input  flow_op_e    op,
   input  logic [7:0]  sreg,
   input  logic [2:0]  bit_sel,
   input  logic [7:0]  cmp_a,
   input  logic [7:0]  cmp_b,
   input  logic [7:0]  test_byte,
   output logic        is_skip,
   output logic        is_branch,
   output logic        cond_true
);

   logic tbit;
   logic fbit;
   logic signed_ge;

   assign tbit      = test_byte[bit_sel];
   assign fbit      = sreg[bit_sel];
   assign signed_ge = (sreg[FLAG_N] == sreg[FLAG_V]);

   always_comb begin
      is_skip   = 1'b0;
      is_branch = 1'b0;
      cond_true = 1'b0;
      unique case (op)
         OP_CPSE:            begin is_skip = 1'b1;   cond_true = (cmp_a == cmp_b); end
         OP_SKRC, OP_SKIOC:  begin is_skip = 1'b1;   cond_true = ~tbit;            end
         OP_SKRS, OP_SKIOS:  begin is_skip = 1'b1;   cond_true = tbit;             end
         OP_BRSET:           begin is_branch = 1'b1; cond_true = fbit;             end
         OP_BRCLR:           begin is_branch = 1'b1; cond_true = ~fbit;            end
         OP_BRGE:            begin is_branch = 1'b1; cond_true = signed_ge;        end
         OP_BRLT:            begin is_branch = 1'b1; cond_true = ~signed_ge;       end
         default:            ;
      endcase
   end

endmodule

// File: rtl/flow_target.sv
module flow_target
   import flow_pkg::*;
#(
   parameter int PC_W = 16
) (
   input  flow_op_e              op,
   input  logic [PC_W-1:0]       pc,
   input  logic [OFS_LONG_W-1:0] offset,
   input  logic [PC_W-1:0]       target,
   input  logic [15:0]           zptr,
   input  logic [PC_W-1:0]       pop_data,
   input  logic                  is_skip,
   input  logic                  is_branch,
   input  logic                  cond_true,
   input  logic                  skip_two_word,
   output logic [PC_W-1:0]       pc_next,
   output logic [CYC_W-1:0]      cycles
);

   logic [PC_W-1:0] ofs_long;
   logic [PC_W-1:0] ofs_short;
   logic [PC_W-1:0] rel_dest;
   logic [PC_W-1:0] z_ext;
   logic [PC_W-1:0] seq_pc;
   logic [1:0]      skip_adv;

   assign ofs_long  = {{(PC_W-OFS_LONG_W){offset[OFS_LONG_W-1]}}, offset};
   assign ofs_short = {{(PC_W-OFS_SHORT_W){offset[OFS_SHORT_W-1]}}, offset[OFS_SHORT_W-1:0]};
   // one adder serves both offset widths
   assign rel_dest  = pc + (is_branch ? ofs_short : ofs_long) + PC_W'(1);
   assign seq_pc    = pc + PC_W'(1);
   assign skip_adv  = skip_two_word ? 2'd3 : 2'd2;

   generate
      if (PC_W > 16) begin : g_z_wide
         assign z_ext = {{(PC_W-16){1'b0}}, zptr};
      end else if (PC_W == 16) begin : g_z_equal
         assign z_ext = zptr;
      end else begin : g_z_narrow
         assign z_ext = zptr[PC_W-1:0];
      end
   endgenerate

   always_comb begin
      pc_next = seq_pc;
      cycles  = CYC_W'(1);
      unique case (op)
         OP_RJMP:             begin pc_next = rel_dest; cycles = CYC_W'(2); end
         OP_IJMP:             begin pc_next = z_ext;    cycles = CYC_W'(2); end
         OP_JMP:              begin pc_next = target;   cycles = CYC_W'(3); end
         OP_RCALL:            begin pc_next = rel_dest; cycles = CYC_W'(3); end
         OP_ICALL:            begin pc_next = z_ext;    cycles = CYC_W'(3); end
         OP_RET, OP_RETI:     begin pc_next = pop_data; cycles = CYC_W'(4); end
         default: begin
            if (is_skip && cond_true) begin
               pc_next = pc + PC_W'(skip_adv);
               cycles  = CYC_W'(skip_adv);
            end else if (is_branch && cond_true) begin
               pc_next = rel_dest;
               cycles  = CYC_W'(2);
            end
         end
      endcase
   end

endmodule

// File: rtl/flow_stack.sv
module flow_stack
   import flow_pkg::*;
#(
   parameter int SP_W = 16
) (
   input  logic            op_valid,
   input  flow_op_e        op,
   input  logic [SP_W-1:0] sp,
   output logic            push,
   output logic            pop_req,
   output logic            set_i,
   output logic [SP_W-1:0] pop_addr,
   output logic [SP_W-1:0] sp_next
);

   localparam logic [SP_W-1:0] RA_BYTES = SP_W'(2);

   logic is_call;
   logic is_ret;

   assign is_call  = (op == OP_RCALL) || (op == OP_ICALL);
   assign is_ret   = (op == OP_RET)   || (op == OP_RETI);

   assign push     = is_call;
   assign pop_req  = op_valid & is_ret;
   assign set_i    = (op == OP_RETI);
   assign pop_addr = sp + SP_W'(1);

   always_comb begin
      if (is_call)     sp_next = sp - RA_BYTES;
      else if (is_ret) sp_next = sp + RA_BYTES;
      else             sp_next = sp;
   end

endmodule

// File: rtl/flow_next_pc.sv
module flow_next_pc
   import flow_pkg::*;
#(
   parameter int PC_W = 16,
   parameter int SP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [4:0]        op,
   input  logic [PC_W-1:0]   pc,
   input  logic [11:0]       offset,
   input  logic [PC_W-1:0]   target,
   input  logic [15:0]       zptr,
   input  logic [7:0]        sreg,
   input  logic [2:0]        bit_sel,
   input  logic [7:0]        cmp_a,
   input  logic [7:0]        cmp_b,
   input  logic [7:0]        test_byte,
   input  logic              skip_two_word,
   input  logic [SP_W-1:0]   sp,
   output logic              pop_req,
   output logic [SP_W-1:0]   pop_addr,
   input  logic [PC_W-1:0]   pop_data,
   output logic              res_valid,
   output logic [PC_W-1:0]   res_pc,
   output logic [SP_W-1:0]   res_sp,
   output logic [2:0]        res_cycles,
   output logic              res_push,
   output logic [SP_W-1:0]   res_push_addr,
   output logic [PC_W-1:0]   res_push_data,
   output logic              res_set_i
);

   generate
      if (PC_W < OFS_LONG_W || PC_W > 22) begin : g_bad_pc_w
         $error("flow_next_pc: PC_W must lie in 12..22");
      end
      if (SP_W < 8 || SP_W > 16) begin : g_bad_sp_w
         $error("flow_next_pc: SP_W must lie in 8..16");
      end
   endgenerate

   flow_op_e op_e;
   assign op_e = flow_op_e'(op);

   logic              is_skip;
   logic              is_branch;
   logic              cond_true;
   logic [PC_W-1:0]   pc_next;
   logic [CYC_W-1:0]  cyc_next;
   logic              push_next;
   logic              seti_next;
   logic [SP_W-1:0]   sp_next;

   flow_cond u_cond (
      .op        (op_e),
      .sreg      (sreg),
      .bit_sel   (bit_sel),
      .cmp_a     (cmp_a),
      .cmp_b     (cmp_b),
      .test_byte (test_byte),
      .is_skip   (is_skip),
      .is_branch (is_branch),
      .cond_true (cond_true)
   );

   flow_target #(.PC_W(PC_W)) u_target (
      .op            (op_e),
      .pc            (pc),
      .offset        (offset),
      .target        (target),
      .zptr          (zptr),
      .pop_data      (pop_data),
      .is_skip       (is_skip),
      .is_branch     (is_branch),
      .cond_true     (cond_true),
      .skip_two_word (skip_two_word),
      .pc_next       (pc_next),
      .cycles        (cyc_next)
   );

   flow_stack #(.SP_W(SP_W)) u_stack (
      .op_valid (op_valid),
      .op       (op_e),
      .sp       (sp),
      .push     (push_next),
      .pop_req  (pop_req),
      .set_i    (seti_next),
      .pop_addr (pop_addr),
      .sp_next  (sp_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid     <= 1'b0;
         res_pc        <= '0;
         res_sp        <= '0;
         res_cycles    <= '0;
         res_push      <= 1'b0;
         res_push_addr <= '0;
         res_push_data <= '0;
         res_set_i     <= 1'b0;
      end else begin
         res_valid <= op_valid;
         res_push  <= op_valid & push_next;
         res_set_i <= op_valid & seti_next;
         if (op_valid) begin
            res_pc        <= pc_next;
            res_sp        <= sp_next;
            res_cycles    <= cyc_next;
            res_push_addr <= sp;
            res_push_data <= pc + PC_W'(1);
         end
      end
   end

endmodule

// File: rtl/flow_next_pc_chk.sv
module flow_next_pc_chk
   import flow_pkg::*;
#(
   parameter int PC_W = 16,
   parameter int SP_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            op_valid,
   input logic [4:0]      op,
   input logic [PC_W-1:0] pc,
   input logic [SP_W-1:0] sp,
   input logic            pop_req,
   input logic [SP_W-1:0] pop_addr,
   input logic            res_valid,
   input logic [SP_W-1:0] res_sp,
   input logic [2:0]      res_cycles,
   input logic            res_push,
   input logic [PC_W-1:0] res_push_data,
   input logic            res_set_i
);

   p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid);

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (!res_valid && !res_push && !res_set_i));

   p_call_stack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op == OP_RCALL || op == OP_ICALL)) |=>
         (res_push && res_sp == $past(sp) - SP_W'(2) && res_push_data == $past(pc) + PC_W'(1)));

   p_ret_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op == OP_RET || op == OP_RETI)) |-> (pop_req && pop_addr == sp + SP_W'(1)));

   p_seti_only_reti_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_set_i |-> ($past(op) == OP_RETI && $past(op_valid)));

   p_push_only_calls_r10: assert property (@(posedge clk) disable iff (!rst_n)
      res_push |-> ($past(op) == OP_RCALL || $past(op) == OP_ICALL));

   p_pop_only_returns_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pop_req |-> (op_valid && (op == OP_RET || op == OP_RETI)));

   p_cycle_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_cycles >= 3'd1 && res_cycles <= 3'd4));

endmodule

bind flow_next_pc flow_next_pc_chk #(.PC_W(PC_W), .SP_W(SP_W)) u_chk (.*);

// File: tb/flow_next_pc_tb.sv
module flow_next_pc_tb;

   localparam int PC_W = 16;
   localparam int SP_W = 16;
   localparam logic [15:0] SP0 = 16'h08FF;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              op_valid = 1'b0;
   logic [4:0]        op = '0;
   logic [PC_W-1:0]   pc = '0;
   logic [11:0]       offset = '0;
   logic [PC_W-1:0]   target = '0;
   logic [15:0]       zptr = '0;
   logic [7:0]        sreg = '0;
   logic [2:0]        bit_sel = '0;
   logic [7:0]        cmp_a = '0;
   logic [7:0]        cmp_b = '0;
   logic [7:0]        test_byte = '0;
   logic              skip_two_word = 1'b0;
   logic [SP_W-1:0]   sp = '0;
   logic              pop_req;
   logic [SP_W-1:0]   pop_addr;
   logic [PC_W-1:0]   pop_data = '0;
   logic              res_valid;
   logic [PC_W-1:0]   res_pc;
   logic [SP_W-1:0]   res_sp;
   logic [2:0]        res_cycles;
   logic              res_push;
   logic [SP_W-1:0]   res_push_addr;
   logic [PC_W-1:0]   res_push_data;
   logic              res_set_i;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   flow_next_pc #(.PC_W(PC_W), .SP_W(SP_W)) u_dut (.*);

   typedef struct packed {
      logic [4:0]  op;
      logic [15:0] pc;
      logic [11:0] k;
      logic [15:0] tgt;
      logic [15:0] z;
      logic [7:0]  sr;
      logic [2:0]  bs;
      logic [7:0]  a;
      logic [7:0]  b;
      logic [7:0]  tb;
      logic        two;
      logic [15:0] popd;
      logic [15:0] epc;
      logic [15:0] esp;
      logic [2:0]  ecyc;
      logic        epush;
      logic        eseti;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t VECS [NV] = '{
      // R10 sequential
      '{5'd0, 16'h0100, 12'h000, 16'h0, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0, 16'h0101, 16'h08FF, 3'd1, 1'b0, 1'b0, 8'd10},
      // R3 relative jump forward, backward, wrap
      '{5'd1, 16'h0100, 12'h005, 16'h0, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0, 16'h0106, 16'h08FF, 3'd2, 1'b0, 1'b0, 8'd3},
      '{5'd1, 16'h0100, 12'hFFE, 16'h0, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0, 16'h00FF, 16'h08FF, 3'd2, 1'b0, 1'b0, 8'd3},
      '{5'd1, 16'hFFFF, 12'h000, 16'h0, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0, 16'h0000, 16'h08FF, 3'd2, 1'b0, 1'b0, 8'd3},
      // R4 indirect and absolute jump
      '{5'd2, 16'h0100, 12'h000, 16'h0, 16'h1234, 8'h00, 3'd0, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0, 16'h1234, 16'h08FF, 3'd2, 1'b0, 1'b0, 8'd4},
      '{5'd3, 16'h0100, 12'h000, 16'hABCD, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0, 16'hABCD, 16'h08FF, 3'd3, 1'b0, 1'b0, 8'd4},
      // R5 calls
      '{5'd4, 16'h0100, 12'h010, 16'h0, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0, 16'h0111, 16'h08FD, 3'd3, 1'b1, 1'b0, 8'd5},
      '{5'd5, 16'h0100, 12'h000, 16'h0, 16'h0400, 8'h00, 3'd0, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0, 16'h0400, 16'h08FD, 3'd3, 1'b1, 1'b0, 8'd5},
      // R6 returns
      '{5'd6, 16'h0100, 12'h000, 16'h0, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0222, 16'h0222, 16'h0901, 3'd4, 1'b0, 1'b0, 8'd6},
      '{5'd7, 16'h0100, 12'h000, 16'h0, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0333, 16'h0333, 16'h0901, 3'd4, 1'b0, 1'b1, 8'd6},
      // R7 compare-skip equal, unequal, two-word
      '{5'd8, 16'h0100, 12'h000, 16'h0, 16'h0, 8'h00, 3'd0, 8'h5, 8'h5, 8'h00, 1'b0, 16'h0, 16'h0102, 16'h08FF, 3'd2, 1'b0, 1'b0, 8'd7},
      '{5'd8, 16'h0100, 12'h000, 16'h0, 16'h0, 8'h00, 3'd0, 8'h5, 8'h6, 8'h00, 1'b0, 16'h0, 16'h0101, 16'h08FF, 3'd1, 1'b0, 1'b0, 8'd7},
      '{5'd8, 16'h0100, 12'h000, 16'h0, 16'h0, 8'h00, 3'd0, 8'h5, 8'h5, 8'h00, 1'b1, 16'h0, 16'h0103, 16'h08FF, 3'd3, 1'b0, 1'b0, 8'd7},
      // R7 bit skips
      '{5'd9, 16'h0100, 12'h000, 16'h0, 16'h0, 8'h00, 3'd2, 8'h0, 8'h0, 8'hFB, 1'b0, 16'h0, 16'h0102, 16'h08FF, 3'd2, 1'b0, 1'b0, 8'd7},
      '{5'd10, 16'h0100, 12'h000, 16'h0, 16'h0, 8'h00, 3'd7, 8'h0, 8'h0, 8'h80, 1'b0, 16'h0, 16'h0102, 16'h08FF, 3'd2, 1'b0, 1'b0, 8'd7},
      '{5'd10, 16'h0100, 12'h000, 16'h0, 16'h0, 8'h00, 3'd7, 8'h0, 8'h0, 8'h7F, 1'b0, 16'h0, 16'h0101, 16'h08FF, 3'd1, 1'b0, 1'b0, 8'd7},
      '{5'd11, 16'h0100, 12'h000, 16'h0, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 8'h01, 1'b0, 16'h0, 16'h0101, 16'h08FF, 3'd1, 1'b0, 1'b0, 8'd7},
      '{5'd12, 16'h0100, 12'h000, 16'h0, 16'h0, 8'h00, 3'd4, 8'h0, 8'h0, 8'h10, 1'b1, 16'h0, 16'h0103, 16'h08FF, 3'd3, 1'b0, 1'b0, 8'd7},
      // R8 flag branches; third one has upper offset bits set, which are ignored
      '{5'd13, 16'h0100, 12'h003, 16'h0, 16'h0, 8'h02, 3'd1, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0, 16'h0104, 16'h08FF, 3'd2, 1'b0, 1'b0, 8'd8},
      '{5'd13, 16'h0100, 12'h003, 16'h0, 16'h0, 8'h7F, 3'd7, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0, 16'h0101, 16'h08FF, 3'd1, 1'b0, 1'b0, 8'd8},
      '{5'd14, 16'h0100, 12'hF7E, 16'h0, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0, 16'h00FF, 16'h08FF, 3'd2, 1'b0, 1'b0, 8'd8},
      // R9 signed branches
      '{5'd15, 16'h0100, 12'h010, 16'h0, 16'h0, 8'h0C, 3'd0, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0, 16'h0111, 16'h08FF, 3'd2, 1'b0, 1'b0, 8'd9},
      '{5'd15, 16'h0100, 12'h010, 16'h0, 16'h0, 8'h04, 3'd0, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0, 16'h0101, 16'h08FF, 3'd1, 1'b0, 1'b0, 8'd9},
      '{5'd16, 16'h0100, 12'h010, 16'h0, 16'h0, 8'h04, 3'd0, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0, 16'h0111, 16'h08FF, 3'd2, 1'b0, 1'b0, 8'd9},
      '{5'd16, 16'h0100, 12'h010, 16'h0, 16'h0, 8'h0C, 3'd0, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0, 16'h0101, 16'h08FF, 3'd1, 1'b0, 1'b0, 8'd9},
      // R10 unused code
      '{5'd17, 16'h0100, 12'h000, 16'h0, 16'h0, 8'h00, 3'd0, 8'h0, 8'h0, 8'h00, 1'b0, 16'h0, 16'h0101, 16'h08FF, 3'd1, 1'b0, 1'b0, 8'd10}
   };

   task automatic chk(input bit ok, input int req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      op = v.op; pc = v.pc; offset = v.k; target = v.tgt; zptr = v.z;
      sreg = v.sr; bit_sel = v.bs; cmp_a = v.a; cmp_b = v.b;
      test_byte = v.tb; skip_two_word = v.two; pop_data = v.popd;
      sp = SP0; op_valid = 1'b1;
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         errors++;
         $display("FAIL R2 watchdog: actual %h expected %h", 32'd0, 32'd1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(res_valid == 1'b0 && res_pc == '0 && res_sp == '0 && res_cycles == '0,
          1, "reset outputs", {res_valid, res_cycles, res_pc[11:0]}, 32'd0);
      chk(res_push == 1'b0 && res_set_i == 1'b0 && res_push_addr == '0 && res_push_data == '0,
          1, "reset strobes", {res_push, res_set_i}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VECS[i]);
         #1;
         if (VECS[i].op == 5'd6 || VECS[i].op == 5'd7) begin
            chk(pop_req == 1'b1 && pop_addr == SP0 + 16'd1, 6, "pop request",
                {15'd0, pop_req, pop_addr}, {16'd1, SP0 + 16'd1});
         end else begin
            chk(pop_req == 1'b0, 10, "no pop", {31'd0, pop_req}, 32'd0);
         end
         @(negedge clk);
         op_valid = 1'b0;
         chk(res_valid == 1'b1, 2, "valid", {31'd0, res_valid}, 32'd1);
         chk(res_pc == VECS[i].epc, int'(VECS[i].req), $sformatf("pc vec%0d", i),
             {16'd0, res_pc}, {16'd0, VECS[i].epc});
         chk(res_sp == VECS[i].esp, int'(VECS[i].req), $sformatf("sp vec%0d", i),
             {16'd0, res_sp}, {16'd0, VECS[i].esp});
         chk(res_cycles == VECS[i].ecyc, int'(VECS[i].req), $sformatf("cycles vec%0d", i),
             {29'd0, res_cycles}, {29'd0, VECS[i].ecyc});
         chk(res_push == VECS[i].epush && res_set_i == VECS[i].eseti, int'(VECS[i].req),
             $sformatf("strobes vec%0d", i), {30'd0, res_push, res_set_i},
             {30'd0, VECS[i].epush, VECS[i].eseti});
         if (VECS[i].epush) begin
            // R5 saved address and data
            chk(res_push_addr == SP0 && res_push_data == VECS[i].pc + 16'd1, 5, "push payload",
                {res_push_addr, res_push_data}, {SP0, VECS[i].pc + 16'd1});
         end
      end

      // R2 idle cycle: no valid, strobes low, result held
      @(negedge clk);
      chk(res_valid == 1'b0 && res_push == 1'b0 && res_set_i == 1'b0, 2, "idle strobes",
          {res_valid, res_push, res_set_i}, 32'd0);
      chk(res_pc == 16'h0101 && res_cycles == 3'd1, 2, "idle hold",
          {13'd0, res_cycles, res_pc}, {13'd0, 3'd1, 16'h0101});

      // R1 asynchronous reset clears a live result
      @(negedge clk);
      drive(VECS[6]);
      @(negedge clk);
      op_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      chk(res_valid == 1'b0 && res_push == 1'b0 && res_pc == '0 && res_sp == '0, 1,
          "reset mid-run", {res_valid, res_push, res_pc[13:0], res_sp[15:0]}, 32'd0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule